// File: doc/BRIEF.md
# CAN Message FIFO Window

This block is the message buffer between a host processor and a CAN protocol engine. It holds two four-entry queues: one for transmission and one for reception. The host reaches each queue through one fixed mailbox window of four 32-bit registers.

To send a frame, the host fills the transmit window with an ID word, a length code and eight data bytes. It then writes the key value 0xFF to the transmit advance register. That write commits the window as one queue entry. The protocol engine takes entries in commit order on a valid/ready port, and each accepted handshake counts as one completed transmission.

Received frames arrive from the engine on a valid port. The receive window always shows the oldest stored frame. Writing 0xFF to the receive advance register releases that frame, and the window then shows the next one. Two sticky flags record receive and transmit activity. The host clears a flag by writing zero to its bit. The interrupt line is the OR of each flag gated by its enable bit.

Top module: `can_mbx_window`

Register word addresses (`reg_addr`):

| Address | Register | Access |
|---|---|---|
| 0 | Transmit ID word | read/write |
| 1 | Transmit length code, bits 3:0 | read/write |
| 2 | Transmit data bytes 0 to 3, byte k at bits 8k+7:8k | read/write |
| 3 | Transmit data bytes 4 to 7, byte 4+k at bits 8k+7:8k | read/write |
| 4 | Receive ID word | read |
| 5 | Receive length code (bits 3:0) and timestamp (bits 31:16) | read |
| 6 | Receive data bytes 0 to 3 | read |
| 7 | Receive data bytes 4 to 7 | read |
| 8 | Transmit control | read/write |
| 9 | Transmit advance (key 0xFF in bits 7:0) | write |
| 10 | Receive control | read/write |
| 11 | Receive advance (key 0xFF in bits 7:0) | write |
| 12 | Interrupt status | read/write |
| 13 | Interrupt enable | read/write |

## Requirements
- R1: After reset both queues are empty and both enable bits are 0. Transmit control (address 8) reads 0, receive control (address 10) reads 0x80, interrupt status reads 0, `irq`, `tx_valid` and `rx_ready` are low, and the receive ID word reads 0.
- R2: While transmit control bit 0 is 1, a write of 0xFF in bits 7:0 of address 9 commits the transmit window as one entry. The unsent count in transmit control bits 3:1 then goes up by one. Any other value written to address 9 has no effect.
- R3: A commit while four entries are unsent is ignored. The unsent count stays at 4, and the ignored frame never appears on the transmit port.
- R4: `tx_valid` is high while transmission is enabled and at least one entry is unsent. Frames leave in commit order, and each handshake lowers the unsent count by one. The transmit port fields decode the ID word as follows:
  - `tx_ext` is bit 31 and `tx_rtr` is bit 30.
  - `tx_id` is bits 28:0 when bit 31 is set, and bits 28:18 zero-extended otherwise.
  - `tx_dlc` is the low 4 bits of the length register.
  - Data byte k is at `tx_data[8k+7:8k]`.
- R5: While transmit control bit 0 is 0, `tx_valid` is low and commits are ignored. Stored entries are kept and are offered again once the bit is set.
- R6: While receive control bit 0 is 1, `rx_ready` is high and a frame on `rx_valid` is stored. The receive window then shows it as follows:
  - ID word: bit 31 = extended, bit 30 = remote, an extended ID at bits 28:0, a standard ID at bits 28:18.
  - Address 5: length code in bits 3:0, timestamp in bits 31:16.
  - Data bytes ordered as in the transmit window.
  - Receive control bit 7 reads 0 while a frame is stored and 1 while the queue is empty.
  - While bit 0 is 0, `rx_ready` is low and nothing is stored.
- R7: A write of 0xFF to address 11 releases the oldest received frame, so the window shows the next one in arrival order. A release with the queue empty is ignored. An empty queue shows zero in all four receive window words.
- R8: A frame that arrives while four frames are stored is dropped, and the stored frames are unchanged. `rx_overrun` is high for exactly the one cycle after the dropped frame's clock edge.
- R9: Interrupt status bit 4 sets on each stored receive frame, and bit 3 sets on each transmit handshake. Writing 0 to a status bit clears it and writing 1 leaves it unchanged. A set in the same cycle as a clear leaves the bit set.
- R10: Interrupt enable bit 4 gates the receive flag and bit 3 gates the transmit flag. `irq` is high exactly when some status bit and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| irq | output | 1 | Interrupt request |
| tx_valid | output | 1 | Transmit entry available |
| tx_ready | input | 1 | Engine accepts (and completes) the offered entry |
| tx_ext | output | 1 | Offered frame uses an extended ID |
| tx_rtr | output | 1 | Offered frame is a remote request |
| tx_id | output | 29 | Offered frame identifier |
| tx_dlc | output | 4 | Offered frame length code |
| tx_data | output | 64 | Offered frame data bytes |
| rx_valid | input | 1 | Engine presents a received frame |
| rx_ready | output | 1 | Reception enabled |
| rx_ext | input | 1 | Received frame uses an extended ID |
| rx_rtr | input | 1 | Received frame is a remote request |
| rx_id | input | 29 | Received frame identifier |
| rx_dlc | input | 4 | Received frame length code |
| rx_data | input | 64 | Received frame data bytes |
| rx_stamp | input | 16 | Receive timestamp |
| rx_overrun | output | 1 | One-cycle pulse: a frame was dropped on a full queue |

## Verification
The assertions assume the engine holds its transmit handshake only while it wants the offered frame. They also assume the host does not clear the transmit enable in the same cycle it relies on `tx_valid` staying stable. The assertions exclude that cycle, and the bench writes the enable only while `tx_ready` is low.

The bench drives `rx_valid` for exactly one cycle per frame, away from the clock edge. Overrun and the simultaneous set/clear of a flag are therefore each produced in a single known cycle. Receive frames are pushed only while the bench knows the queue depth, so every drop is intentional.

// File: rtl/can_mbx_pkg.sv
package can_mbx_pkg;

    // Field positions inside the mailbox ID word
    localparam int EXT_BIT     = 31;
    localparam int RTR_BIT     = 30;
    localparam int ID_W        = 29;
    localparam int STD_ID_W    = 11;
    localparam int STD_ID_LSB  = 18;

    // Control / interrupt bit positions
    localparam int CTL_EN_BIT   = 0;
    localparam int RX_EMPTY_BIT = 7;
    localparam int IRQ_RX_BIT   = 4;
    localparam int IRQ_TX_BIT   = 3;

    localparam logic [7:0] ADVANCE_KEY = 8'hFF;

    // Register word addresses
    localparam int RA_TX_ID   = 0;
    localparam int RA_TX_LEN  = 1;
    localparam int RA_TX_DLO  = 2;
    localparam int RA_TX_DHI  = 3;
    localparam int RA_RX_ID   = 4;
    localparam int RA_RX_LEN  = 5;
    localparam int RA_RX_DLO  = 6;
    localparam int RA_RX_DHI  = 7;
    localparam int RA_TX_CTL  = 8;
    localparam int RA_TX_ADV  = 9;
    localparam int RA_RX_CTL  = 10;
    localparam int RA_RX_ADV  = 11;
    localparam int RA_IRQ_STS = 12;
    localparam int RA_IRQ_EN  = 13;

    typedef struct packed {
        logic [31:0] idw;
        logic [3:0]  dlc;
        logic [63:0] data;
    } mbx_frame_t;

    typedef struct packed {
        mbx_frame_t  frame;
        logic [15:0] stamp;
    } mbx_rx_entry_t;

    function automatic logic [31:0] idw_pack(input logic ext, input logic rtr,
                                             input logic [ID_W-1:0] id);
        if (ext)
            return {1'b1, rtr, 1'b0, id};
        return {1'b0, rtr, 1'b0, id[STD_ID_W-1:0], {STD_ID_LSB{1'b0}}};
    endfunction

    function automatic logic [ID_W-1:0] idw_id(input logic [31:0] w);
        if (w[EXT_BIT])
            return w[ID_W-1:0];
        return {{(ID_W-STD_ID_W){1'b0}}, w[STD_ID_LSB +: STD_ID_W]};
    endfunction

endpackage

// File: rtl/can_mbx_fifo.sv
module can_mbx_fifo #(
    parameter int W     = 100,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head_data,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t   st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic       do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full      = (st_q.cnt == CNT_W'(DEPTH));
    assign empty     = (st_q.cnt == '0);
    assign count     = st_q.cnt;
    assign head_data = mem_q[st_q.rd];
    assign do_push   = push && !full;
    assign do_pop    = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (do_push) st_d.wr = step(st_q.wr);
        if (do_pop)  st_d.rd = step(st_q.rd);
        if (do_push && !do_pop)      st_d.cnt = st_q.cnt + CNT_W'(1);
        else if (do_pop && !do_push) st_d.cnt = st_q.cnt - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= push_data;
    end

    // R3
    cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !full) |=> (count == $past(count) + CNT_W'(1)));

endmodule

// File: rtl/can_mbx_irq.sv
module can_mbx_irq
    import can_mbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_rx,
    input  logic       set_tx,
    input  logic       sts_wr,
    input  logic       en_wr,
    input  logic       wr_rx,
    input  logic       wr_tx,
    output logic [7:0] sts,
    output logic [7:0] en,
    output logic       irq
);

    typedef struct packed {
        logic rx_sts;
        logic tx_sts;
        logic rx_en;
        logic tx_en;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sts_wr) begin
            if (!wr_rx) st_d.rx_sts = 1'b0;
            if (!wr_tx) st_d.tx_sts = 1'b0;
        end
        if (en_wr) begin
            st_d.rx_en = wr_rx;
            st_d.tx_en = wr_tx;
        end
        if (set_rx) st_d.rx_sts = 1'b1;
        if (set_tx) st_d.tx_sts = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        sts = '0;
        en  = '0;
        sts[IRQ_RX_BIT] = st_q.rx_sts;
        sts[IRQ_TX_BIT] = st_q.tx_sts;
        en[IRQ_RX_BIT]  = st_q.rx_en;
        en[IRQ_TX_BIT]  = st_q.tx_en;
    end

    assign irq = (st_q.rx_sts && st_q.rx_en) || (st_q.tx_sts && st_q.tx_en);

    // R9
    rx_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_rx |=> sts[IRQ_RX_BIT]);

    // R9
    tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && !wr_tx && !set_tx) |=> !sts[IRQ_TX_BIT]);

endmodule

// File: rtl/can_mbx_window.sv
module can_mbx_window
    import can_mbx_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              tx_ext,
    output logic              tx_rtr,
    output logic [ID_W-1:0]   tx_id,
    output logic [3:0]        tx_dlc,
    output logic [63:0]       tx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic              rx_ext,
    input  logic              rx_rtr,
    input  logic [ID_W-1:0]   rx_id,
    input  logic [3:0]        rx_dlc,
    input  logic [63:0]       rx_data,
    input  logic [15:0]       rx_stamp,
    output logic              rx_overrun
);

    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int TX_W    = $bits(mbx_frame_t);
    localparam int RX_W    = $bits(mbx_rx_entry_t);
    localparam int UNSENT_W = 3;

    typedef struct packed {
        logic        tx_en;
        logic        rx_en;
        logic [31:0] stage_idw;
        logic [3:0]  stage_dlc;
        logic [31:0] stage_dlo;
        logic [31:0] stage_dhi;
        logic        overrun;
    } win_st_t;

    win_st_t st_d, st_q;

    // Address decode
    logic wr_tx_id, wr_tx_len, wr_tx_dlo, wr_tx_dhi;
    logic wr_tx_ctl, wr_rx_ctl, wr_irq_sts, wr_irq_en;
    logic tx_commit, rx_release, key_hit;

    assign key_hit    = (reg_wdata[7:0] == ADVANCE_KEY);
    assign wr_tx_id   = reg_wr && (reg_addr == ADDR_W'(RA_TX_ID));
    assign wr_tx_len  = reg_wr && (reg_addr == ADDR_W'(RA_TX_LEN));
    assign wr_tx_dlo  = reg_wr && (reg_addr == ADDR_W'(RA_TX_DLO));
    assign wr_tx_dhi  = reg_wr && (reg_addr == ADDR_W'(RA_TX_DHI));
    assign wr_tx_ctl  = reg_wr && (reg_addr == ADDR_W'(RA_TX_CTL));
    assign wr_rx_ctl  = reg_wr && (reg_addr == ADDR_W'(RA_RX_CTL));
    assign wr_irq_sts = reg_wr && (reg_addr == ADDR_W'(RA_IRQ_STS));
    assign wr_irq_en  = reg_wr && (reg_addr == ADDR_W'(RA_IRQ_EN));
    assign tx_commit  = reg_wr && (reg_addr == ADDR_W'(RA_TX_ADV)) && key_hit && st_q.tx_en;
    assign rx_release = reg_wr && (reg_addr == ADDR_W'(RA_RX_ADV)) && key_hit;

    // Transmit queue
    mbx_frame_t       tx_push_frame, tx_head;
    logic [TX_W-1:0]  tx_head_bits;
    logic [CNT_W-1:0] tx_cnt;
    logic             tx_full, tx_empty, tx_pop;

    assign tx_push_frame = '{idw:  st_q.stage_idw,
                             dlc:  st_q.stage_dlc,
                             data: {st_q.stage_dhi, st_q.stage_dlo}};

    can_mbx_fifo #(.W(TX_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tx_commit),
        .push_data (tx_push_frame),
        .pop       (tx_pop),
        .head_data (tx_head_bits),
        .count     (tx_cnt),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    assign tx_head  = mbx_frame_t'(tx_head_bits);
    assign tx_valid = st_q.tx_en && !tx_empty;
    assign tx_pop   = tx_valid && tx_ready;
    assign tx_ext   = tx_head.idw[EXT_BIT];
    assign tx_rtr   = tx_head.idw[RTR_BIT];
    assign tx_id    = idw_id(tx_head.idw);
    assign tx_dlc   = tx_head.dlc;
    assign tx_data  = tx_head.data;

    // Receive queue
    mbx_rx_entry_t    rx_push_entry, rx_head, rx_view;
    logic [RX_W-1:0]  rx_head_bits;
    logic [CNT_W-1:0] rx_cnt;
    logic             rx_full, rx_empty, rx_push, rx_store;

    assign rx_ready = st_q.rx_en;
    assign rx_push  = rx_valid && st_q.rx_en;
    assign rx_store = rx_push && !rx_full;
    assign rx_push_entry = '{frame: '{idw:  idw_pack(rx_ext, rx_rtr, rx_id),
                                      dlc:  rx_dlc,
                                      data: rx_data},
                             stamp: rx_stamp};

    can_mbx_fifo #(.W(RX_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_push),
        .push_data (rx_push_entry),
        .pop       (rx_release),
        .head_data (rx_head_bits),
        .count     (rx_cnt),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    assign rx_head    = mbx_rx_entry_t'(rx_head_bits);
    assign rx_view    = rx_empty ? '0 : rx_head;
    assign rx_overrun = st_q.overrun;

    // Interrupt flags
    logic [7:0] irq_sts, irq_en;

    can_mbx_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_rx (rx_store),
        .set_tx (tx_pop),
        .sts_wr (wr_irq_sts),
        .en_wr  (wr_irq_en),
        .wr_rx  (reg_wdata[IRQ_RX_BIT]),
        .wr_tx  (reg_wdata[IRQ_TX_BIT]),
        .sts    (irq_sts),
        .en     (irq_en),
        .irq    (irq)
    );

    // Next-state
    always_comb begin
        st_d = st_q;
        st_d.overrun = rx_push && rx_full;
        if (wr_tx_id)  st_d.stage_idw = reg_wdata;
        if (wr_tx_len) st_d.stage_dlc = reg_wdata[3:0];
        if (wr_tx_dlo) st_d.stage_dlo = reg_wdata;
        if (wr_tx_dhi) st_d.stage_dhi = reg_wdata;
        if (wr_tx_ctl) st_d.tx_en     = reg_wdata[CTL_EN_BIT];
        if (wr_rx_ctl) st_d.rx_en     = reg_wdata[CTL_EN_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Read mux
    logic [31:0] tx_ctl_word, rx_ctl_word;

    always_comb begin
        tx_ctl_word = '0;
        tx_ctl_word[CTL_EN_BIT] = st_q.tx_en;
        tx_ctl_word[UNSENT_W:1] = UNSENT_W'(tx_cnt);
        rx_ctl_word = '0;
        rx_ctl_word[CTL_EN_BIT]   = st_q.rx_en;
        rx_ctl_word[RX_EMPTY_BIT] = rx_empty;
    end

    always_comb begin
        reg_rdata = '0;
        case (int'(reg_addr))
            RA_TX_ID:   reg_rdata = st_q.stage_idw;
            RA_TX_LEN:  reg_rdata = {28'b0, st_q.stage_dlc};
            RA_TX_DLO:  reg_rdata = st_q.stage_dlo;
            RA_TX_DHI:  reg_rdata = st_q.stage_dhi;
            RA_RX_ID:   reg_rdata = rx_view.frame.idw;
            RA_RX_LEN:  reg_rdata = {rx_view.stamp, 12'b0, rx_view.frame.dlc};
            RA_RX_DLO:  reg_rdata = rx_view.frame.data[31:0];
            RA_RX_DHI:  reg_rdata = rx_view.frame.data[63:32];
            RA_TX_CTL:  reg_rdata = tx_ctl_word;
            RA_RX_CTL:  reg_rdata = rx_ctl_word;
            RA_IRQ_STS: reg_rdata = {24'b0, irq_sts};
            RA_IRQ_EN:  reg_rdata = {24'b0, irq_en};
            default:    reg_rdata = '0;
        endcase
    end

    // R4
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !wr_tx_ctl) |=> (tx_valid && $stable(tx_id) && $stable(tx_data)));

    // R8
    overrun_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> ($past(rx_valid) && $past(rx_ready) && ($past(rx_cnt) == CNT_W'(DEPTH))));

    // R5
    tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && $past(tx_empty)) |-> $past(tx_commit));

endmodule

// File: tb/can_mbx_window_tb.sv
module can_mbx_window_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        tx_valid, tx_ready = 1'b0;
    logic        tx_ext, tx_rtr;
    logic [28:0] tx_id;
    logic [3:0]  tx_dlc;
    logic [63:0] tx_data;
    logic        rx_valid = 1'b0, rx_ready;
    logic        rx_ext = 1'b0, rx_rtr = 1'b0;
    logic [28:0] rx_id = '0;
    logic [3:0]  rx_dlc = '0;
    logic [63:0] rx_data = '0;
    logic [15:0] rx_stamp = '0;
    logic        rx_overrun;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    can_mbx_window u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_ext(tx_ext), .tx_rtr(tx_rtr),
        .tx_id(tx_id), .tx_dlc(tx_dlc), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_ext(rx_ext), .rx_rtr(rx_rtr),
        .rx_id(rx_id), .rx_dlc(rx_dlc), .rx_data(rx_data), .rx_stamp(rx_stamp),
        .rx_overrun(rx_overrun)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = 4'(a); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        reg_addr = 4'(a);
        #1;
        v = reg_rdata;
    endtask

    task automatic check_reg(input string req, input int a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    function automatic logic [31:0] id_word(input logic ext, input logic rtr, input logic [28:0] id);
        if (ext) return 32'h8000_0000 | (32'(rtr) << 30) | 32'(id);
        return (32'(rtr) << 30) | (32'(id[10:0]) << 18);
    endfunction

    task automatic stage_commit(input logic [31:0] idw, input logic [3:0] dlc,
                                input logic [31:0] lo, input logic [31:0] hi);
        wr(0, idw); wr(1, 32'(dlc)); wr(2, lo); wr(3, hi);
        wr(9, 32'hFF);
    endtask

    task automatic pop_expect(input string req, input logic ext, input logic rtr, input logic [28:0] id,
                              input logic [3:0] dlc, input logic [63:0] data);
        check({req, " valid"}, tx_valid, 1'b1);
        check({req, " ext"}, tx_ext, ext);
        check({req, " rtr"}, tx_rtr, rtr);
        check({req, " id"}, tx_id, id);
        check({req, " dlc"}, tx_dlc, dlc);
        check({req, " data"}, tx_data, data);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic rx_push(input logic ext, input logic rtr, input logic [28:0] id,
                           input logic [3:0] dlc, input logic [63:0] data, input logic [15:0] st);
        @(negedge clk);
        rx_valid = 1'b1; rx_ext = ext; rx_rtr = rtr; rx_id = id;
        rx_dlc = dlc; rx_data = data; rx_stamp = st;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic rx_expect(input string req, input logic ext, input logic rtr, input logic [28:0] id,
                             input logic [3:0] dlc, input logic [63:0] data, input logic [15:0] st);
        check_reg({req, " rx id"}, 4, id_word(ext, rtr, id));
        check_reg({req, " rx len"}, 5, {st, 12'b0, dlc});
        check_reg({req, " rx lo"}, 6, data[31:0]);
        check_reg({req, " rx hi"}, 7, data[63:32]);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check_reg("R1 tx ctl", 8, 32'h0);
        check_reg("R1 rx ctl", 10, 32'h80);
        check_reg("R1 irq sts", 12, 32'h0);
        check_reg("R1 rx id", 4, 32'h0);
        check("R1 irq", irq, 1'b0);
        check("R1 tx_valid", tx_valid, 1'b0);
        check("R1 rx_ready", rx_ready, 1'b0);
    endtask

    task automatic t_tx_commit;
        wr(8, 32'h1);
        wr(0, id_word(1'b0, 1'b0, 29'h123));
        wr(1, 32'h8); wr(2, 32'h4433_2211); wr(3, 32'h8877_6655);
        wr(9, 32'h7F);
        check_reg("R2 non-key ignored", 8, 32'h1);
        wr(9, 32'hFF);
        check_reg("R2 unsent one", 8, 32'h3);
        check("R4 std frame offered", tx_valid, 1'b1);
    endtask

    task automatic t_tx_full;
        stage_commit(32'hDABC_DEF5, 4'h0, 32'h0, 32'h0);
        stage_commit(id_word(1'b0, 1'b0, 29'h7FF), 4'h3, 32'h00CC_BBAA, 32'h0);
        stage_commit(32'h8000_0001, 4'hF, 32'h0, 32'hDEAD_BEEF);
        check_reg("R3 unsent four", 8, 32'h9);
        stage_commit(id_word(1'b0, 1'b0, 29'h055), 4'h1, 32'h55, 32'h0);
        check_reg("R3 full commit ignored", 8, 32'h9);
        pop_expect("R4 f1", 1'b0, 1'b0, 29'h123, 4'h8, 64'h8877_6655_4433_2211);
        check_reg("R4 unsent after pop", 8, 32'h7);
        pop_expect("R4 f2", 1'b1, 1'b1, 29'h1ABC_DEF5, 4'h0, 64'h0);
        pop_expect("R4 f3", 1'b0, 1'b0, 29'h7FF, 4'h3, 64'h00CC_BBAA);
        pop_expect("R4 f4", 1'b1, 1'b0, 29'h1, 4'hF, 64'hDEAD_BEEF_0000_0000);
        check("R3 fifth never sent", tx_valid, 1'b0);
        check_reg("R4 unsent zero", 8, 32'h1);
        check_reg("R9 tx flag set", 12, 32'h08);
    endtask

    task automatic t_tx_disabled;
        wr(8, 32'h0);
        stage_commit(id_word(1'b0, 1'b0, 29'h011), 4'h1, 32'h1, 32'h0);
        check_reg("R5 commit ignored when disabled", 8, 32'h0);
        wr(8, 32'h1);
        check("R5 nothing queued", tx_valid, 1'b0);
        stage_commit(id_word(1'b0, 1'b1, 29'h022), 4'h2, 32'h0202, 32'h0);
        wr(8, 32'h0);
        check("R5 valid low when disabled", tx_valid, 1'b0);
        check_reg("R5 entry kept", 8, 32'h2);
        wr(8, 32'h1);
        pop_expect("R5 re-offered", 1'b0, 1'b1, 29'h022, 4'h2, 64'h0202);
    endtask

    task automatic t_irq;
        wr(12, 32'h0);
        wr(13, 32'h08);
        check("R10 irq low with no flag", irq, 1'b0);
        stage_commit(id_word(1'b0, 1'b0, 29'h033), 4'h0, 32'h0, 32'h0);
        pop_expect("R9 tx completion", 1'b0, 1'b0, 29'h033, 4'h0, 64'h0);
        check("R10 irq from tx flag", irq, 1'b1);
        wr(12, 32'h08);
        check_reg("R9 write one keeps", 12, 32'h08);
        wr(13, 32'h10);
        check("R10 irq masked", irq, 1'b0);
        check_reg("R10 enable readback", 13, 32'h10);
        wr(12, 32'h00);
        check_reg("R9 write zero clears", 12, 32'h00);
    endtask

    task automatic t_rx;
        rx_push(1'b0, 1'b0, 29'h0AA, 4'h1, 64'h1, 16'h1);
        check_reg("R6 disabled stores nothing", 10, 32'h80);
        check("R6 ready low when disabled", rx_ready, 1'b0);
        wr(10, 32'h1);
        check("R6 ready high", rx_ready, 1'b1);
        rx_push(1'b0, 1'b0, 29'h2A5, 4'h2, 64'hBEEF, 16'h1234);
        check_reg("R6 not empty", 10, 32'h01);
        rx_expect("R6 std", 1'b0, 1'b0, 29'h2A5, 4'h2, 64'hBEEF, 16'h1234);
        check("R10 irq rx", irq, 1'b1);
        check_reg("R9 rx flag", 12, 32'h10);
        rx_push(1'b1, 1'b1, 29'h1234_5678, 4'h0, 64'h0, 16'hABCD);
        rx_push(1'b1, 1'b0, 29'h0000_0007, 4'h8, 64'h0102_0304_0506_0708, 16'h0002);
        rx_push(1'b0, 1'b1, 29'h400, 4'h0, 64'h0, 16'h0003);
        check("R8 no overrun before full", rx_overrun, 1'b0);
        rx_push(1'b0, 1'b0, 29'h111, 4'h1, 64'hFF, 16'h0004);
        check("R8 overrun pulse", rx_overrun, 1'b1);
        @(negedge clk);
        check("R8 overrun one cycle", rx_overrun, 1'b0);
        rx_expect("R8 head unchanged", 1'b0, 1'b0, 29'h2A5, 4'h2, 64'hBEEF, 16'h1234);
        wr(11, 32'h12);
        rx_expect("R7 non-key no release", 1'b0, 1'b0, 29'h2A5, 4'h2, 64'hBEEF, 16'h1234);
        wr(11, 32'hFF);
        rx_expect("R7 second", 1'b1, 1'b1, 29'h1234_5678, 4'h0, 64'h0, 16'hABCD);
        wr(11, 32'hFF);
        rx_expect("R7 third", 1'b1, 1'b0, 29'h7, 4'h8, 64'h0102_0304_0506_0708, 16'h2);
        wr(11, 32'hFF);
        rx_expect("R8 fourth kept", 1'b0, 1'b1, 29'h400, 4'h0, 64'h0, 16'h3);
        wr(11, 32'hFF);
        check_reg("R7 empty again", 10, 32'h81);
        rx_expect("R7 empty window zero", 1'b0, 1'b0, 29'h0, 4'h0, 64'h0, 16'h0);
        wr(11, 32'hFF);
        check_reg("R7 release on empty ignored", 10, 32'h81);
        rx_push(1'b0, 1'b0, 29'h0B0, 4'h1, 64'h5A, 16'h9);
        rx_expect("R7 after empty release", 1'b0, 1'b0, 29'h0B0, 4'h1, 64'h5A, 16'h9);
    endtask

    task automatic t_set_wins;
        wr(11, 32'hFF);
        wr(12, 32'h0);
        check_reg("R9 cleared before race", 12, 32'h0);
        @(negedge clk);
        rx_valid = 1'b1; rx_id = 29'h0C0; rx_dlc = 4'h0; rx_data = '0; rx_stamp = '0;
        rx_ext = 1'b0; rx_rtr = 1'b0;
        reg_addr = 4'd12; reg_wdata = 32'h0; reg_wr = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; reg_wr = 1'b0;
        check_reg("R9 set wins over clear", 12, 32'h10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tx_commit();
        t_tx_full();
        t_tx_disabled();
        t_irq();
        t_rx();
        t_set_wins();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule